// File: doc/BRIEF.md
# Dual Reload Interval Timer

This block holds two periodic down-counters that share one tick strobe. Both sit behind a small register port. The first timer, the acknowledged timer, runs from a reload value. It counts down by two on each tick while it is armed and while a gate bit in a mask register is set. When it runs out it raises a level interrupt, and that interrupt stays high until software touches the status register. Touching the status register clears the interrupt and refills the count.

The second timer, the free-running timer, is switched on by any nonzero period. It counts down by five on each tick. Each time it falls below one it refills itself from the period and emits a single-cycle interrupt pulse.

Software reads and writes the registers through a strobe, a write flag, an address and a data bus. Read data is combinational and reflects the state before the access takes effect at the clock edge.

Top module: `dual_ival_timer`

## Requirements
- R1: A write to the reload register (address 0) stores the value both as the reload value and as the current count of the acknowledged timer.
- R2: On a tick, the acknowledged timer's signed count drops by exactly 2, but only when the reload value is above 0, the count is above 0, and bit 1 of the mask register (address 2) is 1. Otherwise the count is unchanged.
- R3: `irq_level` rises on the clock edge where a decrement leaves the count at 0 or below. It then stays high until the status register is accessed.
- R4: Any access to the status register (address 1), read or write, clears `irq_level` and loads the count from the reload value. Write data is discarded. A read returns the count as it was before this refill.
- R5: The free-running timer counts only while its period register (address 3) is nonzero. A tick then lowers its signed count by 5. With a period of 0, `irq_pulse` stays low.
- R6: When a tick takes the free-running count below 1, the count is loaded from the period and `irq_pulse` is high in the following cycle. The count starts at 0 after reset, so the first enabled tick expires at once.
- R7: `irq_pulse` is high for exactly one cycle per expiry.
- R8: A read of address 0 returns the stored reload value, never the running count.
- R9: Reads of address 2 return the mask and reads of address 3 return the period. Reads of addresses 4 and above return 0, writes to them change nothing, and `acc_rdata` is 0 when no read is under way.
- R10: Reset clears every register, both counts and both interrupt outputs.
- R11: A register write or status access in the same cycle as a tick wins over that tick's decrement of the acknowledged timer. The free-running timer steps with its old period when its period is written in a tick cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count strobe shared by both timers |
| acc_en | input | 1 | Register access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Register index |
| acc_wdata | input | CNT_W | Write data |
| acc_rdata | output | CNT_W | Read data, combinational |
| irq_level | output | 1 | Acknowledged timer interrupt, level |
| irq_pulse | output | 1 | Free-running timer interrupt, one-cycle pulse |

## Verification
Some properties are checked on every cycle:
- a status access always leaves `irq_level` low on the next cycle;
- `irq_level` never drops without such an access;
- `irq_level` rises and `irq_pulse` appears only after a tick;
- unmapped reads return zero;
- reset clears both outputs.

Other behaviour needs the bench's scenarios, which compare against a cycle model:
- the step sizes of two and five;
- the three-way arming condition;
- the value a status read returns before its refill;
- the immediate first expiry of the free-running timer;
- the order in which a same-cycle write and tick take effect.

// File: rtl/ditmr_pkg.sv
package ditmr_pkg;
    localparam int REG_RELOAD = 0;
    localparam int REG_STATUS = 1;
    localparam int REG_MASK   = 2;
    localparam int REG_PERIOD = 3;
    localparam int REG_COUNT  = 4;
endpackage

// File: rtl/ditmr_acked_timer.sv
module ditmr_acked_timer #(
    parameter int CNT_W = 16,
    parameter int STEP  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick,
    input  logic                    gate,
    input  logic                    load_en,
    input  logic [CNT_W-1:0]        load_val,
    input  logic                    ack,
    output logic signed [CNT_W-1:0] reload_o,
    output logic signed [CNT_W-1:0] count_o,
    output logic                    irq_o
);
    localparam logic signed [CNT_W-1:0] STEP_V = CNT_W'(STEP);

    typedef struct packed {
        logic signed [CNT_W-1:0] reload;
        logic signed [CNT_W-1:0] count;
        logic                    irq;
    } state_t;

    state_t st_d, st_q;
    logic   armed;

    always_comb begin
        st_d  = st_q;
        armed = gate && (st_q.reload > 0) && (st_q.count > 0);
        if (load_en) begin
            st_d.reload = load_val;
            st_d.count  = load_val;
        end else if (ack) begin
            st_d.count = st_q.reload;
            st_d.irq   = 1'b0;
        end else if (tick && armed) begin
            st_d.count = st_q.count - STEP_V;
            if (st_d.count <= 0) begin
                st_d.irq = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reload_o = st_q.reload;
    assign count_o  = st_q.count;
    assign irq_o    = st_q.irq;
endmodule

// File: rtl/ditmr_auto_timer.sv
module ditmr_auto_timer #(
    parameter int CNT_W = 16,
    parameter int STEP  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_val,
    output logic [CNT_W-1:0] period_o,
    output logic             pulse_o
);
    localparam int EXT_W = CNT_W + 1;
    localparam logic signed [EXT_W-1:0] STEP_V = EXT_W'(STEP);

    typedef struct packed {
        logic signed [CNT_W-1:0] period;
        logic signed [CNT_W-1:0] count;
        logic                    pulse;
    } state_t;

    state_t                  st_d, st_q;
    logic signed [EXT_W-1:0] diff;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        diff       = {st_q.count[CNT_W-1], st_q.count} - STEP_V;
        if (tick && (st_q.period != 0)) begin
            if (diff <= 0) begin
                st_d.count = st_q.period;
                st_d.pulse = 1'b1;
            end else begin
                st_d.count = diff[CNT_W-1:0];
            end
        end
        if (wr_en) begin
            st_d.period = wr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign period_o = st_q.period;
    assign pulse_o  = st_q.pulse;
endmodule

// File: rtl/ditmr_regfile.sv
module ditmr_regfile
    import ditmr_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int CNT_W    = 16,
    parameter int GATE_BIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [CNT_W-1:0]  acc_wdata,
    input  logic [CNT_W-1:0]  reload_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [CNT_W-1:0]  period_i,
    output logic              ld_reload,
    output logic              ack_status,
    output logic              wr_period,
    output logic              gate_o,
    output logic [CNT_W-1:0]  acc_rdata
);
    typedef struct packed {
        logic [CNT_W-1:0] mask;
    } state_t;

    state_t st_d, st_q;
    logic   hit_reload, hit_status, hit_mask, hit_period;

    always_comb begin
        hit_reload = (acc_addr == ADDR_W'(REG_RELOAD));
        hit_status = (acc_addr == ADDR_W'(REG_STATUS));
        hit_mask   = (acc_addr == ADDR_W'(REG_MASK));
        hit_period = (acc_addr == ADDR_W'(REG_PERIOD));

        ld_reload  = acc_en && acc_wr && hit_reload;
        ack_status = acc_en && hit_status;
        wr_period  = acc_en && acc_wr && hit_period;

        st_d = st_q;
        if (acc_en && acc_wr && hit_mask) begin
            st_d.mask = acc_wdata;
        end

        acc_rdata = '0;
        if (acc_en && !acc_wr) begin
            if (hit_reload) begin
                acc_rdata = reload_i;
            end else if (hit_status) begin
                acc_rdata = count_i;
            end else if (hit_mask) begin
                acc_rdata = st_q.mask;
            end else if (hit_period) begin
                acc_rdata = period_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gate_o = st_q.mask[GATE_BIT];
endmodule

// File: rtl/dual_ival_timer.sv
module dual_ival_timer #(
    parameter int ADDR_W   = 3,
    parameter int CNT_W    = 16,
    parameter int STEP_A   = 2,
    parameter int STEP_B   = 5,
    parameter int GATE_BIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [CNT_W-1:0]  acc_wdata,
    output logic [CNT_W-1:0]  acc_rdata,
    output logic              irq_level,
    output logic              irq_pulse
);
    logic                    ld_reload, ack_status, wr_period, gate;
    logic signed [CNT_W-1:0] reload_w, count_w;
    logic [CNT_W-1:0]        period_w;

    ditmr_regfile #(
        .ADDR_W  (ADDR_W),
        .CNT_W   (CNT_W),
        .GATE_BIT(GATE_BIT)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_en    (acc_en),
        .acc_wr    (acc_wr),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .reload_i  (reload_w),
        .count_i   (count_w),
        .period_i  (period_w),
        .ld_reload (ld_reload),
        .ack_status(ack_status),
        .wr_period (wr_period),
        .gate_o    (gate),
        .acc_rdata (acc_rdata)
    );

    ditmr_acked_timer #(
        .CNT_W(CNT_W),
        .STEP (STEP_A)
    ) acked_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .gate    (gate),
        .load_en (ld_reload),
        .load_val(acc_wdata),
        .ack     (ack_status),
        .reload_o(reload_w),
        .count_o (count_w),
        .irq_o   (irq_level)
    );

    ditmr_auto_timer #(
        .CNT_W(CNT_W),
        .STEP (STEP_B)
    ) auto_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .wr_en   (wr_period),
        .wr_val  (acc_wdata),
        .period_o(period_w),
        .pulse_o (irq_pulse)
    );
endmodule

// File: rtl/ditmr_checker.sv
module ditmr_checker
    import ditmr_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              acc_en,
    input logic              acc_wr,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [CNT_W-1:0]  acc_rdata,
    input logic              irq_level,
    input logic              irq_pulse
);
    logic status_touch;
    assign status_touch = acc_en && (acc_addr == ADDR_W'(REG_STATUS));

    assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        status_touch |=> !irq_level);

    assert_level_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level && !status_touch) |=> irq_level);

    assert_level_needs_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_level) |-> $past(tick));

    assert_pulse_needs_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(tick));

    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_wr && acc_addr >= ADDR_W'(REG_COUNT)) |-> (acc_rdata == '0));

    assert_reset_clears_R10: assert property (@(posedge clk)
        !rst_n |=> (!irq_level && !irq_pulse));
endmodule

bind dual_ival_timer ditmr_checker #(
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .acc_en   (acc_en),
    .acc_wr   (acc_wr),
    .acc_addr (acc_addr),
    .acc_rdata(acc_rdata),
    .irq_level(irq_level),
    .irq_pulse(irq_pulse)
);

// File: tb/dual_ival_timer_tb_top.sv
`timescale 1ns/1ps
module dual_ival_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        acc_en = 1'b0;
    logic        acc_wr = 1'b0;
    logic [2:0]  acc_addr = '0;
    logic [15:0] acc_wdata = '0;
    logic [15:0] acc_rdata;
    logic        irq_level, irq_pulse;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int pulses_seen = 0;
    int last_rd = 0;

    // reference model state
    int m_reload = 0, m_cur = 0, m_irq = 0, m_mask = 0, m_period = 0, m_cntb = 0, m_pulse = 0;

    always #2 clk = ~clk;

    dual_ival_timer dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .acc_en(acc_en), .acc_wr(acc_wr),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .irq_level(irq_level), .irq_pulse(irq_pulse)
    );

    function automatic int sx(input int v);
        logic signed [15:0] t;
        t = v[15:0];
        return int'(t);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input bit tk, input bit en, input bit wr, input int ad, input int wd);
        int exp_rd;
        @(negedge clk);
        chk("R3 irq_level", int'(irq_level), m_irq);
        chk("R7 irq_pulse", int'(irq_pulse), m_pulse);
        if (irq_pulse) pulses_seen++;
        tick = tk; acc_en = en; acc_wr = wr; acc_addr = 3'(ad); acc_wdata = 16'(wd);
        #1;
        exp_rd = 0;
        if (en && !wr) begin
            case (ad)
                0: exp_rd = m_reload;
                1: exp_rd = m_cur;
                2: exp_rd = m_mask;
                3: exp_rd = m_period;
                default: exp_rd = 0;
            endcase
        end
        last_rd = sx(int'(acc_rdata));
        chk((ad == 0) ? "R8 read" : (ad == 1) ? "R4 read" : "R9 read",
            int'(acc_rdata), exp_rd & 16'hFFFF);
        // free-running timer steps with old period
        m_pulse = 0;
        if (tk && m_period != 0) begin
            if (m_cntb - 5 < 1) begin
                m_cntb = m_period;
                m_pulse = 1;
            end else begin
                m_cntb = m_cntb - 5;
            end
        end
        // acknowledged timer
        if (en && wr && ad == 0) begin
            m_reload = sx(wd);
            m_cur = m_reload;
        end else if (en && ad == 1) begin
            m_cur = m_reload;
            m_irq = 0;
        end else if (tk && m_mask[1] && m_reload > 0 && m_cur > 0) begin
            m_cur = m_cur - 2;
            if (m_cur <= 0) m_irq = 1;
        end
        if (en && wr && ad == 2) m_mask = wd & 16'hFFFF;
        if (en && wr && ad == 3) m_period = sx(wd);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        chk("R10 irq_level", int'(irq_level), 0);
        chk("R10 irq_pulse", int'(irq_pulse), 0);
        rst_n = 1'b1;
        cyc(0, 1, 0, 0, 0);
        chk("R10 reload read", last_rd, 0);

        // R1 / R8: reload write loads both values
        cyc(0, 1, 1, 0, 6);
        cyc(0, 1, 0, 0, 0);
        chk("R1 reload", last_rd, 6);
        // R2: gate bit clear, ticks have no effect
        cyc(1, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0);
        cyc(0, 1, 0, 1, 0);
        chk("R2 gated count", last_rd, 6);
        // open gate, count 6 -> 4 -> 2 -> 0
        cyc(0, 1, 1, 2, 2);
        cyc(1, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0);
        cyc(0, 1, 0, 0, 0);
        chk("R8 reload not count", last_rd, 6);
        cyc(1, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        chk("R3 irq set", int'(irq_level), 1);
        cyc(1, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        chk("R3 irq held", int'(irq_level), 1);
        // R4: status read returns 0 then refills and clears
        cyc(0, 1, 0, 1, 0);
        chk("R4 pre-refill value", last_rd, 0);
        cyc(0, 1, 0, 1, 0);
        chk("R4 refilled", last_rd, 6);
        chk("R4 irq cleared", int'(irq_level), 0);
        // R11: status write in a tick cycle wins
        cyc(1, 1, 1, 1, 99);
        cyc(0, 1, 0, 1, 0);
        chk("R11 ack over tick", last_rd, 6);

        // R5 / R6: free-running timer with period 12
        pulses_seen = 0;
        cyc(1, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        chk("R5 off no pulse", pulses_seen, 0);
        cyc(0, 1, 1, 3, 12);
        for (int i = 0; i < 8; i++) begin
            cyc(1, 0, 0, 0, 0);
            cyc(0, 0, 0, 0, 0);
        end
        cyc(0, 0, 0, 0, 0);
        chk("R6 pulse count", pulses_seen, 3);
        cyc(0, 1, 1, 3, 0);

        // R9: unmapped write ignored, read zero
        cyc(0, 1, 1, 5, 77);
        cyc(0, 1, 0, 5, 0);
        chk("R9 unmapped", last_rd, 0);
        cyc(0, 1, 0, 2, 0);
        chk("R9 mask read", last_rd, 2);

        // mixed random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            int a, w;
            a = $urandom_range(0, 5);
            w = ($urandom_range(0, 9) == 0) ? int'($urandom) : int'($urandom_range(0, 40)) - 4;
            if (a == 2 && $urandom_range(0, 3) != 0) w = w | 2;
            cyc($urandom_range(0, 1), $urandom_range(0, 9) < 2, $urandom_range(0, 1), a, w);
        end
        cyc(0, 0, 0, 0, 0);
        finish_run();
    end
endmodule